// File: doc/BRIEF.md
# Categorized Serial Mode Register for a CCD Timing Generator

This block is the configuration port of a CCD sensor timing generator. A host writes 48-bit frames over three wires: a serial clock, a data line and a strobe. Bit 0 comes first, and each bit is sampled on the rising serial clock while the strobe is low. The strobe rising ends the frame. A frame is kept only if it carried exactly 48 clocks and its first eight bits hold the chip-enable code. A two-bit category then sends the payload either to the control register or to the shutter register.

Each field group waits in a shadow register until its own apply event:

- The power state takes effect as soon as the strobe rises.
- Drive mode, line pattern and autofocus shift count take effect at the falling edge of the vertical sync.
- Shutter mode, ADC clock phase and the three shutter counts take effect at the falling edge of the horizontal sync on a line marked as the readout line.

All serial and sync inputs are asynchronous and pass through synchronizers inside the block. The decoded fields drive the pulse generators of the timing generator directly.

Top module: `ccd_serial_cfg`

## Requirements
- R1: After reset, drive mode, shutter mode, pattern, AF shift count, power state and the three shutter counts are zero, and the ADC phase code is 01 (90 degrees).
- R2: A frame is discarded unless frame bits 7..0 equal 8'h81 (bit 0 = 1, bits 1..6 = 0, bit 7 = 1); a discarded frame changes no output, even after later sync edges.
- R3: A frame whose strobe rises after any number of serial clocks other than 48 (for example 47 or 49) is discarded.
- R4: Category bits 9:8 route the frame: 00 writes the control register, 01 writes the shutter register, and 1x writes nothing. A shutter frame never alters a control field, and a control frame never alters a shutter field.
- R5: The power state is taken from control bits 39:38 at the accepted strobe rise, with no wait for a sync edge. Code x0 gives state 0 (run), 01 gives state 1 (sleep) and 11 gives state 2 (standby); state 3 never appears.
- R6: Drive mode (control bits 12:10), pattern select (bit 15) and AF shift count (bits 23:16) change only at a falling vertical sync. Before that they keep their old values.
- R7: Shutter mode (control bits 14:13) and ADC phase code (bits 37:36) change only at a falling horizontal sync while the readout-line input is high. A horizontal fall outside the readout line and a vertical fall leave them unchanged.
- R8: Shutter vertical count (shutter bits 19:10), horizontal count (bits 31:20) and pulse position (bits 41:32) change only at a falling horizontal sync on the readout line.
- R9: Several frames may arrive before an apply event. The last accepted frame of each category wins, and both categories written in one vertical period are all applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, bit 0 first |
| ser_stb_i | input | 1 | Strobe; low during a frame, rising edge ends it |
| hsync_i | input | 1 | Horizontal sync, falling edge is an apply event |
| vsync_i | input | 1 | Vertical sync, falling edge is an apply event |
| readout_line_i | input | 1 | High on the readout line; qualifies the horizontal apply |
| drv_mode_o | output | 3 | Applied drive mode |
| sht_mode_o | output | 2 | Applied shutter mode |
| pat_pal_o | output | 1 | Applied line pattern select |
| af_shift_o | output | 8 | Applied autofocus frame shift count |
| adc_phase_o | output | 2 | Applied ADC clock phase code (0/90/180/270 degrees) |
| pwr_state_o | output | 2 | Power state: 0 run, 1 sleep, 2 standby |
| sht_vcnt_o | output | 10 | Applied shutter vertical period count |
| sht_hcnt_o | output | 12 | Applied shutter horizontal period count |
| sht_pos_o | output | 10 | Applied high-speed shutter pulse position |

## Verification
The main function is tried with frames that differ in exactly one respect from a good one:

- a wrong chip code;
- 47 or 49 clocks instead of 48;
- the test category instead of control or shutter.

Each tells whether that single check is enforced. Accepted frames are followed by sync edges in a deliberate order: a horizontal fall off the readout line, a vertical fall, then a horizontal fall on the readout line. This separates which field group follows which event. Back-to-back control frames, mixed with a shutter frame in the same period, show that the last write wins and that the categories do not disturb each other.

// File: rtl/ccd_cfg_pkg.sv
package ccd_cfg_pkg;
  localparam int FRAME_BITS = 48;
  localparam logic [7:0] CHIP_CODE = 8'h81;
  localparam logic [1:0] CAT_CTL = 2'b00;
  localparam logic [1:0] CAT_SHT = 2'b01;
  localparam logic [1:0] ADC_PHASE_RST = 2'b01;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_STBY  = 2'd2
  } pwr_e;

  // group applied on the vertical sync fall
  typedef struct packed {
    logic [2:0] drv;
    logic       pal;
    logic [7:0] af;
  } vd_grp_t;

  // control group applied on the readout-line horizontal fall
  typedef struct packed {
    logic [1:0] smd;
    logic [1:0] adc;
  } hd_ctl_t;

  // shutter group applied on the readout-line horizontal fall
  typedef struct packed {
    logic [9:0]  vcnt;
    logic [11:0] hcnt;
    logic [9:0]  pos;
  } sht_t;

  localparam hd_ctl_t HD_CTL_RST = '{smd: 2'b00, adc: ADC_PHASE_RST};

  function automatic logic chip_ok(input logic [FRAME_BITS-1:0] f);
    return f[7:0] == CHIP_CODE;
  endfunction

  function automatic pwr_e pwr_decode(input logic [1:0] code);
    if (!code[0])      return PWR_RUN;
    else if (!code[1]) return PWR_SLEEP;
    else               return PWR_STBY;
  endfunction

  function automatic vd_grp_t get_vd_grp(input logic [FRAME_BITS-1:0] f);
    vd_grp_t g;
    g.drv = f[12:10];
    g.pal = f[15];
    g.af  = f[23:16];
    return g;
  endfunction

  function automatic hd_ctl_t get_hd_ctl(input logic [FRAME_BITS-1:0] f);
    hd_ctl_t g;
    g.smd = f[14:13];
    g.adc = f[37:36];
    return g;
  endfunction

  function automatic sht_t get_sht(input logic [FRAME_BITS-1:0] f);
    sht_t g;
    g.vcnt = f[19:10];
    g.hcnt = f[31:20];
    g.pos  = f[41:32];
    return g;
  endfunction
endpackage

// File: rtl/ccd_ser_frame_rx.sv
module ccd_ser_frame_rx
  import ccd_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk_i,
  input  logic                  ser_dat_i,
  input  logic                  ser_stb_i,
  output logic                  frame_ok_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [2:0] SYNC_RST = 3'b100; // strobe idles high

  logic [2:0] stg [SYNC_STAGES];
  logic       clk_s, dat_s, stb_s;
  logic       prev_clk, prev_stb;
  logic       clk_rise, stb_rise;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= SYNC_RST;
    end else begin
      stg[0] <= {ser_stb_i, ser_dat_i, ser_clk_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign {stb_s, dat_s, clk_s} = stg[SYNC_STAGES-1];
  assign clk_rise = clk_s & ~prev_clk;
  assign stb_rise = stb_s & ~prev_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      prev_stb <= 1'b1;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else begin
      prev_clk <= clk_s;
      prev_stb <= stb_s;
      if (stb_s) begin
        bit_cnt <= '0;
      end else if (clk_rise) begin
        shreg <= {dat_s, shreg[FRAME_BITS-1:1]};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frame_ok_o = stb_rise && (bit_cnt == CNT_W'(FRAME_BITS)) && chip_ok(shreg);
  assign frame_o    = shreg;
endmodule

// File: rtl/ccd_line_events.sv
module ccd_line_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic readout_line_i,
  output logic hd_apply_o,
  output logic vd_fall_o
);
  localparam logic [2:0] SYNC_RST = 3'b011; // syncs idle high

  logic [2:0] stg [SYNC_STAGES];
  logic       ro_s, vs_s, hs_s;
  logic       prev_vs, prev_hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= SYNC_RST;
      prev_vs <= 1'b1;
      prev_hs <= 1'b1;
    end else begin
      stg[0] <= {readout_line_i, vsync_i, hsync_i};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
      prev_vs <= vs_s;
      prev_hs <= hs_s;
    end
  end

  assign {ro_s, vs_s, hs_s} = stg[SYNC_STAGES-1];
  assign vd_fall_o  = prev_vs & ~vs_s;
  assign hd_apply_o = prev_hs & ~hs_s & ro_s;
endmodule

// File: rtl/ccd_shadow_reg.sv
module ccd_shadow_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  input  logic         apply_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RST_VAL;
      q_o  <= RST_VAL;
    end else begin
      if (wr_i)    pend <= din_i;
      if (apply_i) q_o  <= pend;
    end
  end
endmodule

// File: rtl/ccd_serial_cfg.sv
module ccd_serial_cfg
  import ccd_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk_i,
  input  logic        ser_dat_i,
  input  logic        ser_stb_i,
  input  logic        hsync_i,
  input  logic        vsync_i,
  input  logic        readout_line_i,
  output logic [2:0]  drv_mode_o,
  output logic [1:0]  sht_mode_o,
  output logic        pat_pal_o,
  output logic [7:0]  af_shift_o,
  output logic [1:0]  adc_phase_o,
  output logic [1:0]  pwr_state_o,
  output logic [9:0]  sht_vcnt_o,
  output logic [11:0] sht_hcnt_o,
  output logic [9:0]  sht_pos_o
);
  localparam int VD_W  = $bits(vd_grp_t);
  localparam int HDC_W = $bits(hd_ctl_t);
  localparam int SHT_W = $bits(sht_t);

  logic                  frame_ok;
  logic [FRAME_BITS-1:0] frame;
  logic                  ctl_wr, sht_wr;
  logic                  hd_apply, vd_fall;
  vd_grp_t               vd_q;
  hd_ctl_t               hdc_q;
  sht_t                  sht_q;
  pwr_e                  pwr_q;

  ccd_ser_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (ser_clk_i),
    .ser_dat_i  (ser_dat_i),
    .ser_stb_i  (ser_stb_i),
    .frame_ok_o (frame_ok),
    .frame_o    (frame)
  );

  ccd_line_events #(.SYNC_STAGES(SYNC_STAGES)) ev_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .hsync_i        (hsync_i),
    .vsync_i        (vsync_i),
    .readout_line_i (readout_line_i),
    .hd_apply_o     (hd_apply),
    .vd_fall_o      (vd_fall)
  );

  // category routing; test category falls through unused
  assign ctl_wr = frame_ok && (frame[9:8] == CAT_CTL);
  assign sht_wr = frame_ok && (frame[9:8] == CAT_SHT);

  ccd_shadow_reg #(.W(VD_W), .RST_VAL('0)) vd_reg_i (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .din_i(get_vd_grp(frame)),
    .apply_i(vd_fall), .q_o(vd_q)
  );

  ccd_shadow_reg #(.W(HDC_W), .RST_VAL(HD_CTL_RST)) hdc_reg_i (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .din_i(get_hd_ctl(frame)),
    .apply_i(hd_apply), .q_o(hdc_q)
  );

  ccd_shadow_reg #(.W(SHT_W), .RST_VAL('0)) sht_reg_i (
    .clk(clk), .rst_n(rst_n), .wr_i(sht_wr), .din_i(get_sht(frame)),
    .apply_i(hd_apply), .q_o(sht_q)
  );

  // power state acts on the strobe rise itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_q <= PWR_RUN;
    else if (ctl_wr) pwr_q <= pwr_decode(frame[39:38]);
  end

  assign drv_mode_o  = vd_q.drv;
  assign pat_pal_o   = vd_q.pal;
  assign af_shift_o  = vd_q.af;
  assign sht_mode_o  = hdc_q.smd;
  assign adc_phase_o = hdc_q.adc;
  assign pwr_state_o = pwr_q;
  assign sht_vcnt_o  = sht_q.vcnt;
  assign sht_hcnt_o  = sht_q.hcnt;
  assign sht_pos_o   = sht_q.pos;
endmodule

// File: rtl/ccd_serial_cfg_chk.sv
module ccd_serial_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       vd_fall,
  input logic       hd_apply,
  input logic [2:0] drv_mode,
  input logic [1:0] adc_phase,
  input logic [1:0] pwr_state,
  input logic [9:0] sht_vcnt
);
  // R5
  pwr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);

  // R5
  pwr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_state) |-> $past(ctl_wr));

  // R6
  drv_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_mode) |-> $past(vd_fall));

  // R7
  adc_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_phase) |-> $past(hd_apply));

  // R8
  vcnt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sht_vcnt) |-> $past(hd_apply));
endmodule

bind ccd_serial_cfg ccd_serial_cfg_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .vd_fall   (vd_fall),
  .hd_apply  (hd_apply),
  .drv_mode  (drv_mode_o),
  .adc_phase (adc_phase_o),
  .pwr_state (pwr_state_o),
  .sht_vcnt  (sht_vcnt_o)
);

// File: tb/ccd_serial_cfg_tb_top.sv
module ccd_serial_cfg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b1;
  logic hsync = 1'b1, vsync = 1'b1, ro_line = 1'b0;
  logic [2:0]  drv;  logic [1:0] smd; logic pal; logic [7:0] af;
  logic [1:0]  adc;  logic [1:0] pwr;
  logic [9:0]  vcnt; logic [11:0] hcnt; logic [9:0] pos;

  always #10 clk = ~clk;

  ccd_serial_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_stb_i(ser_stb), .hsync_i(hsync), .vsync_i(vsync),
    .readout_line_i(ro_line), .drv_mode_o(drv), .sht_mode_o(smd),
    .pat_pal_o(pal), .af_shift_o(af), .adc_phase_o(adc), .pwr_state_o(pwr),
    .sht_vcnt_o(vcnt), .sht_hcnt_o(hcnt), .sht_pos_o(pos)
  );

  typedef struct {
    logic [49:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench model: pending and applied values
  logic [2:0] p_drv = 0, m_drv = 0;  logic p_pal = 0, m_pal = 0;
  logic [7:0] p_af = 0, m_af = 0;
  logic [1:0] p_smd = 0, m_smd = 0, p_adc = 2'b01, m_adc = 2'b01, m_pwr = 0;
  logic [9:0] p_v = 0, m_v = 0, p_p = 0, m_p = 0;
  logic [11:0] p_h = 0, m_h = 0;

  function automatic logic [47:0] ctl_frame(logic [7:0] chip, logic [1:0] cat,
      logic [2:0] mode, logic [1:0] sm, logic pl, logic [7:0] afc,
      logic [1:0] ph, logic [1:0] st);
    logic [47:0] f = '0;
    f[7:0] = chip; f[9:8] = cat; f[12:10] = mode; f[14:13] = sm;
    f[15] = pl; f[23:16] = afc; f[37:36] = ph; f[39:38] = st;
    return f;
  endfunction

  function automatic logic [47:0] sht_frame(logic [7:0] chip, logic [1:0] cat,
      logic [9:0] v, logic [11:0] h, logic [9:0] p);
    logic [47:0] f = '0;
    f[7:0] = chip; f[9:8] = cat; f[19:10] = v; f[31:20] = h; f[41:32] = p;
    return f;
  endfunction

  task automatic send(logic [47:0] f, int nbits);
    @(negedge clk); ser_stb = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 48) ? f[i] : 1'b0;
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk); ser_stb = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits == 48 && f[7:0] == 8'h81) begin
      if (f[9:8] == 2'b00) begin
        p_drv = f[12:10]; p_pal = f[15]; p_af = f[23:16];
        p_smd = f[14:13]; p_adc = f[37:36];
        m_pwr = !f[38] ? 2'd0 : (!f[39] ? 2'd1 : 2'd2);
      end else if (f[9:8] == 2'b01) begin
        p_v = f[19:10]; p_h = f[31:20]; p_p = f[41:32];
      end
    end
  endtask

  task automatic vd_pulse();
    @(negedge clk); vsync = 1'b0;
    repeat (10) @(negedge clk); vsync = 1'b1;
    repeat (6) @(negedge clk);
    m_drv = p_drv; m_pal = p_pal; m_af = p_af;
  endtask

  task automatic hd_pulse(bit ro);
    @(negedge clk); ro_line = ro;
    repeat (4) @(negedge clk); hsync = 1'b0;
    repeat (10) @(negedge clk); hsync = 1'b1; ro_line = 1'b0;
    repeat (6) @(negedge clk);
    if (ro) begin
      m_smd = p_smd; m_adc = p_adc; m_v = p_v; m_h = p_h; m_p = p_p;
    end
  endtask

  task automatic expect_state(string tag);
    item_t it;
    repeat (4) @(negedge clk);
    it.exp = {m_drv, m_smd, m_pal, m_af, m_adc, m_pwr, m_v, m_h, m_p};
    it.tag = tag;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [49:0] act;
        it = sb_q.pop_front();
        act = {drv, smd, pal, af, adc, pwr, vcnt, hcnt, pos};
        vectors++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_state("R1 reset values");

    send(ctl_frame(8'h81, 2'b00, 3'd3, 2'd1, 1'b1, 8'h69, 2'd2, 2'b01), 48);
    expect_state("R5 sleep at strobe, R6/R7 fields still pending");
    hd_pulse(0);
    expect_state("R7 horizontal fall off readout line ignored");
    vd_pulse();
    expect_state("R6 vertical fall applies drive/pattern/AF, R7 untouched");
    hd_pulse(1);
    expect_state("R7 readout horizontal fall applies shutter mode and phase");

    send(sht_frame(8'h81, 2'b01, 10'd2, 12'h10F, 10'd1), 48);
    expect_state("R4 shutter frame leaves control fields");
    vd_pulse();
    expect_state("R8 shutter counts wait through vertical fall");
    hd_pulse(1);
    expect_state("R8 shutter counts applied on readout line");

    send(ctl_frame(8'h80, 2'b00, 3'd5, 2'd3, 1'b0, 8'hAA, 2'd3, 2'b11), 48);
    vd_pulse(); hd_pulse(1);
    expect_state("R2 wrong chip code discarded");

    send(ctl_frame(8'h81, 2'b00, 3'd6, 2'd2, 1'b0, 8'h11, 2'd0, 2'b11), 47);
    vd_pulse(); hd_pulse(1);
    expect_state("R3 47-clock frame discarded");
    send(ctl_frame(8'h81, 2'b00, 3'd6, 2'd2, 1'b0, 8'h11, 2'd0, 2'b11), 49);
    vd_pulse(); hd_pulse(1);
    expect_state("R3 49-clock frame discarded");

    send(ctl_frame(8'h81, 2'b10, 3'd7, 2'd3, 1'b0, 8'h22, 2'd3, 2'b11), 48);
    vd_pulse(); hd_pulse(1);
    expect_state("R4 test category writes nothing");

    send(ctl_frame(8'h81, 2'b00, 3'd4, 2'd3, 1'b0, 8'h33, 2'd3, 2'b11), 48);
    expect_state("R5 standby code 11 gives state 2");
    send(sht_frame(8'h81, 2'b01, 10'h3FF, 12'h7FF, 10'h155), 48);
    send(ctl_frame(8'h81, 2'b00, 3'd2, 2'd2, 1'b1, 8'hFF, 2'd0, 2'b10), 48);
    expect_state("R5 code 10 returns to run");
    vd_pulse(); hd_pulse(1);
    expect_state("R9 last control frame and shutter frame both applied");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule